// File: doc/BRIEF.md
# Parallel Port Microsequencer

This block is a small microcoded controller that drives the data and control registers of a parallel port and watches its status lines. A host writes a microprogram into an internal instruction memory and may preload a local byte buffer. It then pulses `start`. The engine fetches and runs instructions from address 0 until a return instruction ends the program. At that point it presents an 8-bit return code together with a one-cycle `done` pulse.

The instruction set covers several groups:
- register reads into the buffer, and register writes;
- read-modify-write of a register, with separate bit masks for setting and clearing;
- delays counted in microseconds;
- a signed loop register with decrement-and-branch;
- three branch forms that test the status byte against masks;
- a single level of subroutine call and return;
- repeated register transfers that walk the buffer through an auto-incrementing pointer.

Misuse of the call level and unknown opcodes end the run with reserved error codes.

An instruction word is 29 bits wide. The opcode sits in bits [28:24], and three 8-bit operands follow: A in [23:16], B in [15:8] and C in [7:0]. The register-select values are 0 for data, 1 for status and 2 for control. On a read, data returns the `pp_din` lines, status returns `pp_status`, control returns the control latch and select 3 returns 0. Only the data and control latches can be written.

Top module: `mseq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `ret_code`, `pp_dout` and `pp_ctrl` are all 0.
- R2: When `start` is sampled while idle, execution begins at address 0 with the loop register and pointer cleared, and `busy` is high from the next edge. A `start` while busy is ignored. `done` is a one-cycle pulse in the same cycle that `busy` falls.
- R3: Return (opcode 10) ends the run with code A. Every plain instruction takes two cycles, so a lone return raises `done` two edges after `start` is sampled.
- R4: Register write (opcode 4) loads B into the register selected by A. Writes to select 1 or 3 change neither output. Outputs never change while idle.
- R5: Register set (opcode 3) makes the selected register `(old | B) & ~C`.
- R6: Register fetch (opcode 2) stores `(register selected by A) & B` into buffer byte C.
- R7: Delay (opcode 5) stalls for A times CLK_MHZ cycles when A > 0, plus one extra cycle. A = 0 costs nothing beyond the two cycles.
- R8: Opcode 6 loads A into a signed 8-bit loop register. Opcode 7 decrements it and branches to PC+1+signed(C) only if the result is greater than 0.
- R9: Opcode 8 branches to PC+1+signed(C) if any bit of A is 1 in `pp_status`. Opcode 9 branches if any bit of A is 0 in `pp_status`.
- R10: Opcode 14 branches to PC+1+signed(C) only when all bits of A are 1 and all bits of B are 0 in `pp_status`.
- R11: Opcode 12 loads the pointer with A. Opcode 17 writes A successive buffer bytes from the pointer into the register selected by B, taking two cycles per byte and advancing the pointer each time. A = 0 does nothing.
- R12: Opcode 18 stores A successive bytes of `(register selected by B) & C` at the pointer, one per cycle, advancing the pointer each time.
- R13: Call (opcode 16) jumps to A and saves PC+1. Subreturn (opcode 15) resumes there.
- R14: The following end the run with an error code: a call inside a call (0xFE), a subreturn with no open call (0xFF), a return inside a call (0xFC), and any other opcode (0xFD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write strobe |
| prog_addr | input | IMEM_AW | Instruction memory write address |
| prog_word | input | 29 | Instruction word to write |
| buf_we | input | 1 | Buffer write strobe from host, used while idle |
| buf_addr | input | BUF_AW | Host buffer write address |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_raddr | input | BUF_AW | Host buffer read address, used while idle |
| buf_rdata | output | 8 | Buffer byte, one edge after `buf_raddr` |
| start | input | 1 | Begin a program at address 0 |
| pp_din | input | 8 | Port data lines as read back |
| pp_status | input | 8 | Port status lines |
| pp_dout | output | 8 | Data register latch |
| pp_ctrl | output | 8 | Control register latch |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| ret_code | output | 8 | Return or error code of the last run |

## Verification
Every result is timed from the edge that samples `start`. Each plain instruction takes two edges, so a program of n plain instructions raises `done` on edge 2n. The bench turns this into exact, arithmetically derived cycle counts:
- a delay of A adds A·CLK_MHZ + 1 edges;
- a pointer write of A bytes adds 2A edges, and a pointer fetch of A bytes adds A;
- a loop of k iterations costs 2k + 4 edges in total.

These counts are compared against the edge count the bench observes, and the sweeps cover branch conditions over the full status byte. Buffer contents are read back while idle through the host port. The read data is sampled one edge after the address is applied, and port outputs are sampled just after the edge that ends a run.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  localparam logic [4:0] OP_RFETCH  = 5'd2;
  localparam logic [4:0] OP_RSET    = 5'd3;
  localparam logic [4:0] OP_RWR     = 5'd4;
  localparam logic [4:0] OP_DELAY   = 5'd5;
  localparam logic [4:0] OP_LDBR    = 5'd6;
  localparam logic [4:0] OP_DECBR   = 5'd7;
  localparam logic [4:0] OP_BRANY   = 5'd8;
  localparam logic [4:0] OP_BRNONE  = 5'd9;
  localparam logic [4:0] OP_RET     = 5'd10;
  localparam logic [4:0] OP_LDPTR   = 5'd12;
  localparam logic [4:0] OP_BRSTATE = 5'd14;
  localparam logic [4:0] OP_SUBRET  = 5'd15;
  localparam logic [4:0] OP_CALL    = 5'd16;
  localparam logic [4:0] OP_PWR     = 5'd17;
  localparam logic [4:0] OP_PFETCH  = 5'd18;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [7:0] ERR_OPEN   = 8'hFC;
  localparam logic [7:0] ERR_BADOP  = 8'hFD;
  localparam logic [7:0] ERR_NEST   = 8'hFE;
  localparam logic [7:0] ERR_ORPHAN = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_PRD, S_PWR, S_PFT
  } state_e;
endpackage

// File: rtl/mseq_sdp_ram.sv
module mseq_sdp_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mseq_us_timer.sv
module mseq_us_timer #(
  parameter int PRESCALE = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] us_in,
  output logic       fin
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;
  logic [7:0]    us_left;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      us_left <= '0;
      run     <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        us_left <= us_in;
        pre     <= PRE_TOP;
        run     <= 1'b1;
      end else if (run) begin
        if (pre == '0) begin
          if (us_left == 8'd1) begin
            run <= 1'b0;
            fin <= 1'b1;
          end else begin
            us_left <= us_left - 8'd1;
            pre     <= PRE_TOP;
          end
        end else begin
          pre <= pre - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mseq_branch_unit.sv
module mseq_branch_unit
  import mseq_pkg::*;
(
  input  logic [4:0]        op,
  input  logic [7:0]        mask_hi,
  input  logic [7:0]        mask_lo,
  input  logic [7:0]        status,
  input  logic signed [7:0] loop_next,
  output logic              take
);
  always_comb begin
    case (op)
      OP_DECBR:   take = (loop_next > 8'sd0);
      OP_BRANY:   take = |(status & mask_hi);
      OP_BRNONE:  take = |(~status & mask_hi);
      OP_BRSTATE: take = ((status & mask_hi) == mask_hi) && ((status & mask_lo) == 8'h00);
      default:    take = 1'b0;
    endcase
  end
endmodule

// File: rtl/mseq_engine.sv
module mseq_engine
  import mseq_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int BUF_AW  = 8,
  parameter int CLK_MHZ = 250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [INSTR_W-1:0] prog_word,
  input  logic               buf_we,
  input  logic [BUF_AW-1:0]  buf_addr,
  input  logic [7:0]         buf_wdata,
  input  logic [BUF_AW-1:0]  buf_raddr,
  output logic [7:0]         buf_rdata,
  input  logic               start,
  input  logic [7:0]         pp_din,
  input  logic [7:0]         pp_status,
  output logic [7:0]         pp_dout,
  output logic [7:0]         pp_ctrl,
  output logic               busy,
  output logic               done,
  output logic [7:0]         ret_code
);
  state_e              state;
  logic [IMEM_AW-1:0]  pc, ret_pc, pc_inc, pc_tgt;
  logic [BUF_AW-1:0]   ptr;
  logic signed [7:0]   loop_q, loop_next;
  logic [7:0]          cnt;
  logic                sub_open;
  logic [INSTR_W-1:0]  imem_q;
  instr_t              ir;
  logic                take, tmr_load, tmr_fin;

  // buffer ports
  logic               bw_en;
  logic [BUF_AW-1:0]  bw_addr, br_addr;
  logic [7:0]         bw_data, buf_q;

  // register access
  logic [1:0] rsel;
  logic [7:0] rd_val, cur_val, reg_wval;
  logic       reg_we;

  assign ir        = instr_t'(imem_q);
  assign pc_inc    = pc + 1'b1;
  assign pc_tgt    = IMEM_AW'(int'(pc) + 1 + int'($signed(ir.c)));
  assign loop_next = loop_q - 8'sd1;
  assign tmr_load  = (state == S_EXEC) && (ir.op == OP_DELAY) && (ir.a != 8'd0);
  assign buf_rdata = buf_q;

  mseq_sdp_ram #(.AW(IMEM_AW), .DW(INSTR_W)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_word),
    .re(state == S_FETCH), .raddr(pc), .rdata(imem_q)
  );

  mseq_sdp_ram #(.AW(BUF_AW), .DW(8)) u_buf (
    .clk(clk), .we(bw_en), .waddr(bw_addr), .wdata(bw_data),
    .re(1'b1), .raddr(br_addr), .rdata(buf_q)
  );

  mseq_us_timer #(.PRESCALE(CLK_MHZ)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .us_in(ir.a), .fin(tmr_fin)
  );

  mseq_branch_unit u_branch (
    .op(ir.op), .mask_hi(ir.a), .mask_lo(ir.b), .status(pp_status),
    .loop_next(loop_next), .take(take)
  );

  // register select and read paths
  always_comb begin
    rsel = (ir.op == OP_PWR || ir.op == OP_PFETCH) ? ir.b[1:0] : ir.a[1:0];
    case (rsel)
      SEL_DATA: begin rd_val = pp_din;    cur_val = pp_dout; end
      SEL_STAT: begin rd_val = pp_status; cur_val = 8'h00;   end
      SEL_CTRL: begin rd_val = pp_ctrl;   cur_val = pp_ctrl; end
      default:  begin rd_val = 8'h00;     cur_val = 8'h00;   end
    endcase
  end

  // register write path
  always_comb begin
    reg_we   = 1'b0;
    reg_wval = 8'h00;
    if (state == S_EXEC && ir.op == OP_RWR) begin
      reg_we   = 1'b1;
      reg_wval = ir.b;
    end else if (state == S_EXEC && ir.op == OP_RSET) begin
      reg_we   = 1'b1;
      reg_wval = (cur_val | ir.b) & ~ir.c;
    end else if (state == S_PWR) begin
      reg_we   = 1'b1;
      reg_wval = buf_q;
    end
  end

  // buffer port arbitration: engine while busy, host while idle
  always_comb begin
    br_addr = busy ? ptr : buf_raddr;
    bw_en   = 1'b0;
    bw_addr = '0;
    bw_data = 8'h00;
    if (state == S_EXEC && ir.op == OP_RFETCH) begin
      bw_en   = 1'b1;
      bw_addr = BUF_AW'(ir.c);
      bw_data = rd_val & ir.b;
    end else if (state == S_PFT) begin
      bw_en   = 1'b1;
      bw_addr = ptr;
      bw_data = rd_val & ir.c;
    end else if (!busy) begin
      bw_en   = buf_we;
      bw_addr = buf_addr;
      bw_data = buf_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_dout <= 8'h00;
      pp_ctrl <= 8'h00;
    end else if (reg_we) begin
      case (rsel)
        SEL_DATA: pp_dout <= reg_wval;
        SEL_CTRL: pp_ctrl <= reg_wval;
        default:  ;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pc       <= '0;
      ret_pc   <= '0;
      ptr      <= '0;
      loop_q   <= 8'sd0;
      cnt      <= 8'd0;
      sub_open <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ret_code <= 8'h00;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            pc       <= '0;
            ptr      <= '0;
            loop_q   <= 8'sd0;
            sub_open <= 1'b0;
            busy     <= 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          pc    <= pc_inc;
          state <= S_FETCH;
          case (ir.op)
            OP_RFETCH, OP_RSET, OP_RWR: ;
            OP_LDBR:  loop_q <= signed'(ir.a);
            OP_LDPTR: ptr <= BUF_AW'(ir.a);
            OP_DELAY: if (ir.a != 8'd0) begin pc <= pc; state <= S_WAIT; end
            OP_DECBR: begin
              loop_q <= loop_next;
              if (take) pc <= pc_tgt;
            end
            OP_BRANY, OP_BRNONE, OP_BRSTATE: if (take) pc <= pc_tgt;
            OP_CALL: begin
              if (sub_open) begin
                state <= S_IDLE; busy <= 1'b0; done <= 1'b1; ret_code <= ERR_NEST;
              end else begin
                ret_pc   <= pc_inc;
                pc       <= IMEM_AW'(ir.a);
                sub_open <= 1'b1;
              end
            end
            OP_SUBRET: begin
              if (!sub_open) begin
                state <= S_IDLE; busy <= 1'b0; done <= 1'b1; ret_code <= ERR_ORPHAN;
              end else begin
                pc       <= ret_pc;
                sub_open <= 1'b0;
              end
            end
            OP_RET: begin
              state    <= S_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              ret_code <= sub_open ? ERR_OPEN : ir.a;
            end
            OP_PWR, OP_PFETCH: begin
              if (ir.a != 8'd0) begin
                pc    <= pc;
                cnt   <= ir.a;
                state <= (ir.op == OP_PWR) ? S_PRD : S_PFT;
              end
            end
            default: begin
              state <= S_IDLE; busy <= 1'b0; done <= 1'b1; ret_code <= ERR_BADOP;
            end
          endcase
        end
        S_WAIT: begin
          if (tmr_fin) begin
            pc    <= pc_inc;
            state <= S_FETCH;
          end
        end
        S_PRD: state <= S_PWR;
        S_PWR, S_PFT: begin
          ptr <= ptr + 1'b1;
          if (cnt == 8'd1) begin
            pc    <= pc_inc;
            state <= S_FETCH;
          end else begin
            cnt   <= cnt - 8'd1;
            state <= (state == S_PWR) ? S_PRD : S_PFT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mseq_engine_chk.sv
module mseq_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] ret_code,
  input logic [7:0] pp_dout,
  input logic [7:0] pp_ctrl
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_end_has_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_code_held_r3: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ret_code));

  p_idle_outputs_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(pp_dout) && $stable(pp_ctrl)));
endmodule

bind mseq_engine mseq_engine_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ret_code(ret_code), .pp_dout(pp_dout), .pp_ctrl(pp_ctrl)
);

// File: tb/mseq_engine_tb.sv
module mseq_engine_tb;
  import mseq_pkg::*;

  localparam int AW  = 6;
  localparam int BW  = 8;
  localparam int MHZ = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst, prog_we, buf_we, start, busy, done;
  logic [AW-1:0]      prog_addr;
  logic [INSTR_W-1:0] prog_word;
  logic [BW-1:0]      buf_addr, buf_raddr;
  logic [7:0]         buf_wdata, buf_rdata, pp_din, pp_status, pp_dout, pp_ctrl, ret_code;

  mseq_engine #(.IMEM_AW(AW), .BUF_AW(BW), .CLK_MHZ(MHZ)) u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_word(prog_word),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .start(start), .pp_din(pp_din), .pp_status(pp_status),
    .pp_dout(pp_dout), .pp_ctrl(pp_ctrl), .busy(busy), .done(done), .ret_code(ret_code)
  );

  int checks = 0;
  int errors = 0;
  int dm = 0;
  int cm = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [INSTR_W-1:0] ins(int op, int a, int b, int c);
    return {op[4:0], a[7:0], b[7:0], c[7:0]};
  endfunction

  task automatic ld(int addr, logic [INSTR_W-1:0] w);
    prog_we = 1'b1; prog_addr = AW'(addr); prog_word = w;
    @(posedge clk); #1;
    prog_we = 1'b0;
  endtask

  task automatic wrbuf(int addr, int val);
    buf_we = 1'b1; buf_addr = BW'(addr); buf_wdata = val[7:0];
    @(posedge clk); #1;
    buf_we = 1'b0;
  endtask

  task automatic rdbuf(int addr, output int val);
    buf_raddr = BW'(addr);
    @(posedge clk); #1;
    val = int'(buf_rdata);
  endtask

  task automatic run(output int cyc);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc == 5) start = 1'b1;  // stray start while busy (R2)
      if (cyc == 6) start = 1'b0;
    end
    if (cyc >= 4000) chk("R2 run timeout", cyc, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, v;
    rst = 1'b1; prog_we = 1'b0; buf_we = 1'b0; start = 1'b0;
    prog_addr = '0; prog_word = '0; buf_addr = '0; buf_raddr = '0; buf_wdata = '0;
    pp_din = 8'h00; pp_status = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ret_code", ret_code, 0);
    chk("R1 dout", pp_dout, 0);
    chk("R1 ctrl", pp_ctrl, 0);

    // R3 lone return: two edges, code passed
    for (int k = 0; k < 6; k++) begin
      ld(0, ins(10, k * 41 + 1, 0, 0));
      run(cyc);
      chk("R3 ret cycles", cyc, 2);
      chk("R3 ret code", ret_code, k * 41 + 1);
      chk("R2 busy low at done", busy, 0);
      @(posedge clk); #1;
      chk("R2 done one cycle", done, 0);
    end

    // R7 delays (stray start at edge 5 must not disturb, R2)
    for (int n = 0; n < 6; n++) begin
      ld(0, ins(5, n, 0, 0));
      ld(1, ins(10, 7, 0, 0));
      run(cyc);
      chk("R7 delay cycles", cyc, (n == 0) ? 4 : 5 + n * MHZ);
      chk("R2 code after stray start", ret_code, 7);
    end

    // R4 / R5 register write and read-modify-write, writes to 1/3 ignored
    for (int i = 0; i < 16; i++) begin
      int sel, init, setm, clrm, res;
      sel  = (i % 2) ? 2 : 0;
      init = (i * 29 + 3) & 255;
      setm = (i * 53) & 255;
      clrm = (i * 71 + 5) & 255;
      res  = (init | setm) & ~clrm & 255;
      ld(0, ins(4, sel, init, 0));
      ld(1, ins(3, sel, setm, clrm));
      ld(2, ins(4, (i % 2) ? 3 : 1, 8'hFF, 0));
      ld(3, ins(10, 0, 0, 0));
      run(cyc);
      if (sel == 0) dm = res; else cm = res;
      chk("R5 rset result data", pp_dout, dm);
      chk("R4 ctrl after ignored write", pp_ctrl, cm);
      chk("R3 four-instruction timing", cyc, 8);
    end

    // R6 register fetch into buffer
    ld(0, ins(2, 1, 8'h5C, 8'h40));
    ld(1, ins(2, 0, 8'hF0, 8'h41));
    ld(2, ins(2, 2, 8'hFF, 8'h42));
    ld(3, ins(10, 0, 0, 0));
    for (int s = 0; s < 256; s += 5) begin
      pp_status = 8'(s);
      pp_din    = 8'(~s);
      run(cyc);
      rdbuf(8'h40, v); chk("R6 fetch status", v, s & 8'h5C);
      rdbuf(8'h41, v); chk("R6 fetch data lines", v, (~s) & 8'hF0);
      rdbuf(8'h42, v); chk("R6 fetch control", v, cm);
    end

    // R8 loop register and decrement-and-branch (branch offset -1)
    for (int k = -2; k < 10; k++) begin
      ld(0, ins(6, k & 255, 0, 0));
      ld(1, ins(7, 0, 0, 8'hFF));
      ld(2, ins(10, 9, 0, 0));
      run(cyc);
      chk("R8 loop cycles", cyc, (k <= 0) ? 6 : 2 * k + 4);
      chk("R8 loop code", ret_code, 9);
    end

    // R9 / R10 branch forms over every status byte
    for (int f = 0; f < 3; f++) begin
      int m1, m2;
      m1 = (f == 2) ? 8'h81 : 8'h88;
      m2 = 8'h30;
      ld(0, ins((f == 0) ? 8 : (f == 1) ? 9 : 14, m1, m2, 1));
      ld(1, ins(10, 1, 0, 0));
      ld(2, ins(10, 2, 0, 0));
      for (int s = 0; s < 256; s++) begin
        int t;
        pp_status = 8'(s);
        if (f == 0)      t = ((s & m1) != 0);
        else if (f == 1) t = ((~s & m1 & 255) != 0);
        else             t = ((s & m1) == m1) && ((s & m2) == 0);
        run(cyc);
        if (f == 2) chk("R10 branch on state", ret_code, t ? 2 : 1);
        else        chk("R9 branch on any set/clear", ret_code, t ? 2 : 1);
      end
    end

    // R11 / R12 pointer transfers
    wrbuf(8'h10, 8'h31); wrbuf(8'h11, 8'h42); wrbuf(8'h12, 8'h53);
    wrbuf(8'h13, 8'h64); wrbuf(8'h16, 8'hEE);
    pp_din = 8'hA7;
    ld(0, ins(12, 8'h10, 0, 0));
    ld(1, ins(17, 4, 0, 0));
    ld(2, ins(18, 2, 0, 8'h0F));
    ld(3, ins(10, 3, 0, 0));
    run(cyc);
    chk("R11 pointer write result", pp_dout, 8'h64);
    chk("R11 R12 transfer cycles", cyc, 18);
    rdbuf(8'h14, v); chk("R12 fetch byte 0", v, 8'h07);
    rdbuf(8'h15, v); chk("R12 fetch byte 1", v, 8'h07);
    rdbuf(8'h16, v); chk("R12 count respected", v, 8'hEE);
    ld(0, ins(17, 0, 0, 0));
    ld(1, ins(10, 4, 0, 0));
    run(cyc);
    chk("R11 zero count keeps data", pp_dout, 8'h64);
    chk("R11 zero count timing", cyc, 4);

    // R13 call and subreturn
    ld(0, ins(16, 8, 0, 0));
    ld(1, ins(10, 5, 0, 0));
    ld(8, ins(4, 2, 8'h5A, 0));
    ld(9, ins(15, 0, 0, 0));
    run(cyc);
    chk("R13 code after subcall", ret_code, 5);
    chk("R13 subroutine effect", pp_ctrl, 8'h5A);
    chk("R13 call timing", cyc, 8);

    // R14 error endings
    ld(9, ins(16, 12, 0, 0));
    run(cyc);
    chk("R14 nested call", ret_code, 8'hFE);
    ld(0, ins(15, 0, 0, 0));
    run(cyc);
    chk("R14 orphan subreturn", ret_code, 8'hFF);
    ld(0, ins(16, 8, 0, 0));
    ld(9, ins(10, 1, 0, 0));
    run(cyc);
    chk("R14 return inside call", ret_code, 8'hFC);
    ld(0, ins(11, 0, 0, 0));
    run(cyc);
    chk("R14 unknown opcode", ret_code, 8'hFD);
    chk("R14 unknown opcode timing", cyc, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule